// File: doc/BRIEF.md
# Flash Read SECDED Checker with Error Capture

This block sits on the read path of an embedded flash array. Every stored word is 72 bits wide: 64 data bits protected by an extended Hamming code of 7 position-parity bits and one overall-parity bit. On each qualified read it recomputes the check information, fixes any single flipped bit, and classifies a two-bit upset as uncorrectable. The repaired data leaves through a one-cycle register stage.

Errors are recorded in a sticky status register. It holds a correction flag and a detection flag, the failing address aligned down to its 8-byte double word, and the bank bit of the access. A correction drives an interrupt line that software can mask. A detection drives a non-maskable event line that cannot be masked. Software clears each flag with a one-cycle write-1 pulse. While a flag is set, the first record is held, with one exception: an uncorrectable error may replace a record that holds only a correction.

Top module: `flash_ecc_guard`

## Requirements
- R1: Codeword layout: `rd_word_i[0]` is the overall even-parity bit over all 72 bits. Index 2^k (1, 2, 4, 8, 16, 32, 64) holds position-parity bit k, which is the XOR of every other index whose binary value has bit k set. Data bit j sits at the j-th index in ascending order that is neither 0 nor a power of two, so data bit 0 is at index 3 and data bit 63 at index 71. A clean codeword returns its data unchanged and sets no flag.
- R2: A single flipped bit at any of the 72 indices is repaired: `rd_data_o` equals the original data, `ecc_corr_o` sets and `ecc_det_o` stays 0. A flip at index 0 or at a parity index leaves the data untouched.
- R3: Two flipped bits at any two distinct indices set `ecc_det_o` and leave `ecc_corr_o` unchanged.
- R4: `rd_valid_o` and `rd_data_o` follow `rd_valid_i` by exactly one clock. `rd_data_o` keeps its value on cycles without a read.
- R5: `corr_irq_o` is high exactly while the correction flag is set and `corr_irq_en_i` is 1. With the enable at 0 the flag still sets, but no interrupt is raised.
- R6: `nmi_o` is high exactly while the detection flag is set, whatever the value of `corr_irq_en_i`.
- R7: On a recorded error, `ecc_addr_o` takes the read address with bits [2:0] forced to 0, and `ecc_bank_o` takes the bank bit.
- R8: While either flag is set, further errors leave `ecc_addr_o` and `ecc_bank_o` unchanged. The one exception is an uncorrectable error arriving while only the correction flag is set, which replaces the record.
- R9: A one-cycle pulse on `clr_corr_i` or `clr_det_i` clears that flag, and its output line is low from the next clock. If a new error of the same kind arrives in the same cycle, the flag stays set and the new error is recorded.
- R10: After reset, the flags, the record, `rd_valid_o`, `rd_data_o`, `corr_irq_o` and `nmi_o` are all 0.
- R11: While `rd_valid_i` is 0, `rd_word_i`, `rd_addr_i` and `rd_bank_i` have no effect on the flags, the record or `rd_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_valid_i | input | 1 | Qualifies the stored word on this cycle |
| rd_word_i | input | 72 | Stored codeword as read from the array |
| rd_addr_i | input | 21 | Byte address of the read |
| rd_bank_i | input | 1 | Bank of the read |
| corr_irq_en_i | input | 1 | Enable for the correction interrupt |
| clr_corr_i | input | 1 | Write-1 pulse clearing the correction flag |
| clr_det_i | input | 1 | Write-1 pulse clearing the detection flag |
| rd_valid_o | output | 1 | Registered read strobe |
| rd_data_o | output | 64 | Registered, corrected data |
| ecc_corr_o | output | 1 | Sticky correction flag |
| ecc_det_o | output | 1 | Sticky uncorrectable flag |
| ecc_addr_o | output | 21 | Recorded double-word address, bits [2:0] zero |
| ecc_bank_o | output | 1 | Recorded bank |
| corr_irq_o | output | 1 | Maskable correction interrupt |
| nmi_o | output | 1 | Non-maskable uncorrectable-error event |

## Verification
The bench builds the block with its default parameters: 64 data bits, a 21-bit address and 3 alignment bits. The 72-bit codeword is therefore small enough that a single-bit upset can be injected at every index, including the overall-parity bit and the top data index 71. The 21-bit address lets the record be checked with bit 20 set and the low three bits forced to zero. Double upsets are placed on parity/parity, data/data and parity/data pairs. The record-priority rules are walked through a directed sequence of correction, uncorrectable error and clear events.

// File: rtl/fecc_pkg.sv
// Shared definitions for the flash read SECDED checker.
// Assumes position-numbered extended Hamming codes: index 0 holds overall parity.
package fecc_pkg;

    // Classification of one read
    typedef enum logic [1:0] {
        ECC_CLEAN  = 2'd0,
        ECC_SINGLE = 2'd1,
        ECC_DOUBLE = 2'd2
    } ecc_kind_e;

    // Smallest number of position-parity bits covering dw data bits
    function automatic int unsigned hamming_par_w(int unsigned dw);
        int unsigned r;
        r = 1;
        for (int unsigned i = 0; i < 16; i++) begin
            if ((32'd1 << r) < dw + r + 1) r = r + 1;
        end
        return r;
    endfunction

    // True when p is a power of two (p > 0)
    function automatic bit is_pow2(int unsigned p);
        return (p != 0) && ((p & (p - 1)) == 0);
    endfunction

endpackage

// File: rtl/fecc_encoder.sv
// Check-bit generator: places data bits at non-power-of-two positions,
// computes each position-parity bit and the overall even parity.
// Purely combinational; used by the decoder to regenerate check bits.
module fecc_encoder
    import fecc_pkg::*;
#(
    parameter  int unsigned DATA_W = 64,
    localparam int unsigned PAR_W  = hamming_par_w(DATA_W),
    localparam int unsigned CODE_W = DATA_W + PAR_W + 1
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CODE_W-1:0] code_o
);

    logic [CODE_W-1:0] placed;
    logic [CODE_W-1:0] body;
    logic [PAR_W-1:0]  hbits;

    // Scatter data bits onto their code positions
    for (genvar p = 0; p < CODE_W; p++) begin : g_place
        if (p == 0 || is_pow2(p)) begin : g_hole
            assign placed[p] = 1'b0;
        end else begin : g_data
            assign placed[p] = data_i[p - $clog2(p) - 1];
        end
    end

    // Each parity bit covers positions whose index has bit k set
    for (genvar k = 0; k < PAR_W; k++) begin : g_par
        logic [CODE_W-1:0] sel;
        for (genvar p = 0; p < CODE_W; p++) begin : g_sel
            if (((p >> k) & 1) != 0) begin : g_in
                assign sel[p] = placed[p];
            end else begin : g_out
                assign sel[p] = 1'b0;
            end
        end
        assign hbits[k] = ^sel;
    end

    // Merge parity bits into the body; index 0 carries overall parity
    for (genvar p = 0; p < CODE_W; p++) begin : g_body
        if (p == 0) begin : g_zero
            assign body[p] = 1'b0;
        end else if (is_pow2(p)) begin : g_chk
            assign body[p] = hbits[$clog2(p)];
        end else begin : g_dat
            assign body[p] = placed[p];
        end
    end

    assign code_o = {body[CODE_W-1:1], ^body};

endmodule

// File: rtl/fecc_decoder.sv
// SECDED decoder: regenerates check bits from the received data, forms the
// syndrome and overall parity, repairs a single upset and classifies the read.
// Assumes the codeword layout produced by fecc_encoder.
module fecc_decoder
    import fecc_pkg::*;
#(
    parameter  int unsigned DATA_W = 64,
    localparam int unsigned PAR_W  = hamming_par_w(DATA_W),
    localparam int unsigned CODE_W = DATA_W + PAR_W + 1
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [DATA_W-1:0] data_o,
    output ecc_kind_e         kind_o
);

    logic [DATA_W-1:0] raw;
    logic [CODE_W-1:0] regen;
    logic [CODE_W-1:0] diff;
    logic [PAR_W-1:0]  syn;
    logic              par_bad;
    logic              fix_en;

    // Gather received data bits and apply the repair mask
    for (genvar p = 1; p < CODE_W; p++) begin : g_pick
        if (!is_pow2(p)) begin : g_d
            assign raw[p - $clog2(p) - 1]    = code_i[p];
            assign data_o[p - $clog2(p) - 1] = code_i[p] ^ (fix_en && (syn == PAR_W'(p)));
        end
    end

    fecc_encoder #(.DATA_W(DATA_W)) u_regen (
        .data_i (raw),
        .code_o (regen)
    );

    // Regenerated word has even parity, so the parity of diff is the parity of code_i
    assign diff    = regen ^ code_i;
    assign par_bad = ^diff;

    for (genvar k = 0; k < PAR_W; k++) begin : g_syn
        assign syn[k] = diff[1 << k];
    end

    assign fix_en = par_bad && (syn != '0);

    // Classify the read from syndrome and overall parity
    always_comb begin
        if (!par_bad) begin
            kind_o = (syn == '0) ? ECC_CLEAN : ECC_DOUBLE;
        end else begin
            kind_o = (32'(syn) < CODE_W) ? ECC_SINGLE : ECC_DOUBLE;
        end
    end

endmodule

// File: rtl/fecc_status.sv
// Sticky ECC status: correction and detection flags, write-1 clears,
// and the failing double-word address and bank with first-error priority
// (an uncorrectable error may replace a correction-only record).
// Assumes clear pulses and events are synchronous to clk.
module fecc_status
    import fecc_pkg::*;
#(
    parameter  int unsigned ADDR_W  = 21,
    parameter  int unsigned ALIGN_W = 3,
    localparam int unsigned DW_W    = ADDR_W - ALIGN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid_i,
    input  ecc_kind_e         ev_kind_i,
    input  logic [DW_W-1:0]   ev_dword_i,
    input  logic              ev_bank_i,
    input  logic              clr_corr_i,
    input  logic              clr_det_i,
    output logic              corr_o,
    output logic              det_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              bank_o
);

    logic            corr_q, det_q, bank_q;
    logic [DW_W-1:0] dword_q;
    logic            corr_keep, det_keep, is_single, is_double, capture;

    // Decide what survives the clears and whether the record is taken
    always_comb begin
        corr_keep = corr_q & ~clr_corr_i;
        det_keep  = det_q  & ~clr_det_i;
        is_single = ev_valid_i && (ev_kind_i == ECC_SINGLE);
        is_double = ev_valid_i && (ev_kind_i == ECC_DOUBLE);
        capture   = (is_single && !corr_keep && !det_keep) ||
                    (is_double && !det_keep);
    end

    // Flag and record registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            corr_q  <= 1'b0;
            det_q   <= 1'b0;
            dword_q <= '0;
            bank_q  <= 1'b0;
        end else begin
            corr_q <= corr_keep | is_single;
            det_q  <= det_keep  | is_double;
            if (capture) begin
                dword_q <= ev_dword_i;
                bank_q  <= ev_bank_i;
            end
        end
    end

    assign corr_o = corr_q;
    assign det_o  = det_q;
    assign addr_o = {dword_q, {ALIGN_W{1'b0}}};
    assign bank_o = bank_q;

endmodule

// File: rtl/flash_ecc_guard.sv
// Top of the flash read SECDED checker: decodes each qualified read,
// registers the repaired data, keeps the sticky error record and drives
// the maskable correction interrupt and the non-maskable event.
// Assumes one read per cycle at most and synchronous software pulses.
module flash_ecc_guard
    import fecc_pkg::*;
#(
    parameter  int unsigned DATA_W  = 64,
    parameter  int unsigned ADDR_W  = 21,
    parameter  int unsigned ALIGN_W = 3,
    localparam int unsigned PAR_W   = hamming_par_w(DATA_W),
    localparam int unsigned CODE_W  = DATA_W + PAR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid_i,
    input  logic [CODE_W-1:0] rd_word_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic              rd_bank_i,
    input  logic              corr_irq_en_i,
    input  logic              clr_corr_i,
    input  logic              clr_det_i,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              ecc_corr_o,
    output logic              ecc_det_o,
    output logic [ADDR_W-1:0] ecc_addr_o,
    output logic              ecc_bank_o,
    output logic              corr_irq_o,
    output logic              nmi_o
);

    logic [DATA_W-1:0] fixed;
    ecc_kind_e         kind;
    logic              addr_lsb_unused;

    assign addr_lsb_unused = ^rd_addr_i[ALIGN_W-1:0];

    fecc_decoder #(.DATA_W(DATA_W)) u_dec (
        .code_i (rd_word_i),
        .data_o (fixed),
        .kind_o (kind)
    );

    // One-cycle output stage for repaired data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_o <= 1'b0;
            rd_data_o  <= '0;
        end else begin
            rd_valid_o <= rd_valid_i;
            if (rd_valid_i) rd_data_o <= fixed;
        end
    end

    fecc_status #(.ADDR_W(ADDR_W), .ALIGN_W(ALIGN_W)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_valid_i (rd_valid_i),
        .ev_kind_i  (kind),
        .ev_dword_i (rd_addr_i[ADDR_W-1:ALIGN_W]),
        .ev_bank_i  (rd_bank_i),
        .clr_corr_i (clr_corr_i),
        .clr_det_i  (clr_det_i),
        .corr_o     (ecc_corr_o),
        .det_o      (ecc_det_o),
        .addr_o     (ecc_addr_o),
        .bank_o     (ecc_bank_o)
    );

    assign corr_irq_o = ecc_corr_o & corr_irq_en_i;
    assign nmi_o      = ecc_det_o;

endmodule

// File: rtl/fecc_guard_checker.sv
// Protocol checks on the ports of flash_ecc_guard, attached by bind.
module fecc_guard_checker #(
    parameter int unsigned ADDR_W = 21
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_valid_i,
    input logic              clr_corr_i,
    input logic              clr_det_i,
    input logic              rd_valid_o,
    input logic              ecc_corr_o,
    input logic              ecc_det_o,
    input logic [ADDR_W-1:0] ecc_addr_o,
    input logic              ecc_bank_o,
    input logic              corr_irq_o,
    input logic              nmi_o
);

    p_valid_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_i |=> rd_valid_o);

    p_valid_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid_i |=> !rd_valid_o);

    p_corr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_corr_o && !clr_corr_i |=> ecc_corr_o);

    p_det_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_det_o && !clr_det_i |=> ecc_det_o);

    p_clear_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_corr_i && !rd_valid_i |=> !corr_irq_o);

    p_record_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_det_o && !clr_det_i |=> $stable(ecc_addr_o) && $stable(ecc_bank_o));

    p_nmi_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_o) |-> $past(rd_valid_i));

    p_no_event_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid_i |=> !$rose(ecc_corr_o) && !$rose(ecc_det_o));

endmodule

bind flash_ecc_guard fecc_guard_checker #(.ADDR_W(ADDR_W)) u_guard_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_valid_i (rd_valid_i),
    .clr_corr_i (clr_corr_i),
    .clr_det_i  (clr_det_i),
    .rd_valid_o (rd_valid_o),
    .ecc_corr_o (ecc_corr_o),
    .ecc_det_o  (ecc_det_o),
    .ecc_addr_o (ecc_addr_o),
    .ecc_bank_o (ecc_bank_o),
    .corr_irq_o (corr_irq_o),
    .nmi_o      (nmi_o)
);

// File: tb/flash_ecc_guard_tb_top.sv
module flash_ecc_guard_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] NONE = 8'hFF;

    // Vector: {data, first flip index, second flip index}
    localparam logic [79:0] VEC [0:11] = '{
        {64'h0000_0000_0000_0000, NONE,  NONE },
        {64'hFFFF_FFFF_FFFF_FFFF, NONE,  NONE },
        {64'h0123_4567_89AB_CDEF, 8'd0,  NONE },
        {64'h0123_4567_89AB_CDEF, 8'd1,  NONE },
        {64'hFEDC_BA98_7654_3210, 8'd71, NONE },
        {64'h8000_0000_0000_0001, 8'd3,  NONE },
        {64'h5555_AAAA_5555_AAAA, 8'd64, NONE },
        {64'hDEAD_BEEF_CAFE_F00D, 8'd0,  8'd1 },
        {64'hDEAD_BEEF_CAFE_F00D, 8'd5,  8'd70},
        {64'h1357_9BDF_2468_ACE0, 8'd64, 8'd32},
        {64'h1357_9BDF_2468_ACE0, 8'd71, 8'd0 },
        {64'hFFFF_0000_FFFF_0000, 8'd2,  8'd3 }
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_valid_i = 1'b0;
    logic [71:0] rd_word_i = '0;
    logic [20:0] rd_addr_i = '0;
    logic        rd_bank_i = 1'b0;
    logic        corr_irq_en_i = 1'b0;
    logic        clr_corr_i = 1'b0;
    logic        clr_det_i = 1'b0;
    logic        rd_valid_o;
    logic [63:0] rd_data_o;
    logic        ecc_corr_o, ecc_det_o, ecc_bank_o, corr_irq_o, nmi_o;
    logic [20:0] ecc_addr_o;

    int n_cmp = 0;
    int n_bad = 0;

    flash_ecc_guard dut_i (
        .clk(clk), .rst_n(rst_n), .rd_valid_i(rd_valid_i), .rd_word_i(rd_word_i),
        .rd_addr_i(rd_addr_i), .rd_bank_i(rd_bank_i), .corr_irq_en_i(corr_irq_en_i),
        .clr_corr_i(clr_corr_i), .clr_det_i(clr_det_i), .rd_valid_o(rd_valid_o),
        .rd_data_o(rd_data_o), .ecc_corr_o(ecc_corr_o), .ecc_det_o(ecc_det_o),
        .ecc_addr_o(ecc_addr_o), .ecc_bank_o(ecc_bank_o), .corr_irq_o(corr_irq_o),
        .nmi_o(nmi_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Codeword built from the layout stated in R1
    function automatic logic [71:0] make_word(logic [63:0] d);
        logic [71:0] c = '0;
        logic [6:0]  acc = '0;
        int          j = 0;
        for (int p = 1; p < 72; p++) begin
            if ((p & (p - 1)) != 0) begin
                c[p] = d[j];
                j++;
                if (d[j-1]) acc = acc ^ 7'(p);
            end
        end
        for (int k = 0; k < 7; k++) c[1 << k] = acc[k];
        c[0] = ^c[71:1];
        return c;
    endfunction

    function automatic logic [71:0] upset(logic [71:0] c, logic [7:0] a, logic [7:0] b);
        logic [71:0] r = c;
        if (a != NONE) r[a] = ~r[a];
        if (b != NONE) r[b] = ~r[b];
        return r;
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Read one word; returns at the negedge after the capturing posedge
    task automatic do_read(logic [71:0] w, logic [20:0] a, logic b);
        @(negedge clk);
        rd_valid_i = 1'b1; rd_word_i = w; rd_addr_i = a; rd_bank_i = b;
        @(negedge clk);
        rd_valid_i = 1'b0;
    endtask

    task automatic clear_both();
        @(negedge clk);
        clr_corr_i = 1'b1; clr_det_i = 1'b1;
        @(negedge clk);
        clr_corr_i = 1'b0; clr_det_i = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        logic [63:0] d;
        logic [71:0] w;
        repeat (3) @(negedge clk);
        // R10: reset values
        chk("R10 rd_valid_o", 64'(rd_valid_o), 64'd0);
        chk("R10 rd_data_o", rd_data_o, 64'd0);
        chk("R10 flags", {62'd0, ecc_corr_o, ecc_det_o}, 64'd0);
        chk("R10 record", {42'd0, ecc_addr_o, ecc_bank_o}, 64'd0);
        chk("R10 irq/nmi", {62'd0, corr_irq_o, nmi_o}, 64'd0);
        rst_n = 1'b1;
        corr_irq_en_i = 1'b1;

        // R1 R2 R3: table of clean, single and double upsets
        for (int i = 0; i < 12; i++) begin
            int nflip;
            d = VEC[i][79:16];
            nflip = (VEC[i][15:8] != NONE ? 1 : 0) + (VEC[i][7:0] != NONE ? 1 : 0);
            clear_both();
            do_read(upset(make_word(d), VEC[i][15:8], VEC[i][7:0]), 21'(i * 8), 1'b0);
            if (nflip < 2) chk($sformatf("R1/R2 data vec%0d", i), rd_data_o, d);
            chk($sformatf("R1/R2/R3 corr vec%0d", i), 64'(ecc_corr_o), 64'(nflip == 1));
            chk($sformatf("R3 det vec%0d", i), 64'(ecc_det_o), 64'(nflip == 2));
            chk($sformatf("R5/R6 lines vec%0d", i), {62'd0, corr_irq_o, nmi_o},
                {62'd0, nflip == 1, nflip == 2});
        end

        // R2: every single upset index
        d = 64'hA5A5_0F0F_3C3C_9696;
        w = make_word(d);
        for (int p = 0; p < 72; p++) begin
            clear_both();
            do_read(upset(w, 8'(p), NONE), 21'h0, 1'b0);
            chk($sformatf("R2 data idx%0d", p), rd_data_o, d);
            chk($sformatf("R2 flags idx%0d", p), {62'd0, ecc_corr_o, ecc_det_o}, 64'd2);
        end

        // R4: latency and hold of read data
        clear_both();
        @(negedge clk);
        rd_valid_i = 1'b1; rd_word_i = make_word(64'h1111_2222_3333_4444);
        #1 chk("R4 no early valid", 64'(rd_valid_o), 64'd0);
        @(negedge clk);
        rd_valid_i = 1'b0;
        chk("R4 valid after one clock", 64'(rd_valid_o), 64'd1);
        chk("R4 data after one clock", rd_data_o, 64'h1111_2222_3333_4444);
        @(negedge clk);
        chk("R4 valid drops", 64'(rd_valid_o), 64'd0);
        chk("R4 data held", rd_data_o, 64'h1111_2222_3333_4444);

        // R5: masked correction interrupt
        corr_irq_en_i = 1'b0;
        do_read(upset(make_word(64'h42), 8'd9, NONE), 21'h10, 1'b0);
        chk("R5 flag sets while masked", 64'(ecc_corr_o), 64'd1);
        chk("R5 irq masked", 64'(corr_irq_o), 64'd0);
        corr_irq_en_i = 1'b1;
        #1 chk("R5 irq with enable", 64'(corr_irq_o), 64'd1);

        // R6: event line regardless of enable
        clear_both();
        corr_irq_en_i = 1'b0;
        do_read(upset(make_word(64'h77), 8'd9, 8'd10), 21'h20, 1'b0);
        chk("R6 nmi with enable low", 64'(nmi_o), 64'd1);
        corr_irq_en_i = 1'b1;

        // R7: aligned capture and bank
        clear_both();
        do_read(upset(make_word(64'h99), 8'd40, NONE), 21'h1ABCDF, 1'b1);
        chk("R7 aligned address", 64'(ecc_addr_o), 64'h1ABCD8);
        chk("R7 bank", 64'(ecc_bank_o), 64'd1);

        // R8: record priority
        do_read(upset(make_word(64'h5), 8'd12, NONE), 21'h000100, 1'b0);
        chk("R8 second correction keeps record", 64'(ecc_addr_o), 64'h1ABCD8);
        do_read(upset(make_word(64'h5), 8'd12, 8'd13), 21'h0F0F0F, 1'b0);
        chk("R8 double replaces correction", 64'(ecc_addr_o), 64'h0F0F08);
        chk("R8 bank replaced", 64'(ecc_bank_o), 64'd0);
        do_read(upset(make_word(64'h5), 8'd20, 8'd21), 21'h033333, 1'b1);
        chk("R8 second double keeps record", {42'd0, ecc_addr_o, ecc_bank_o}, {42'd0, 21'h0F0F08, 1'b0});
        do_read(upset(make_word(64'h5), 8'd22, NONE), 21'h044444, 1'b1);
        chk("R8 correction after double keeps record", 64'(ecc_addr_o), 64'h0F0F08);

        // R9: clears and coincident set
        @(negedge clk);
        clr_corr_i = 1'b1;
        @(negedge clk);
        clr_corr_i = 1'b0;
        chk("R9 corr cleared", 64'(ecc_corr_o), 64'd0);
        chk("R9 irq low next clock", 64'(corr_irq_o), 64'd0);
        chk("R9 det untouched", 64'(ecc_det_o), 64'd1);
        @(negedge clk);
        clr_det_i = 1'b1;
        @(negedge clk);
        clr_det_i = 1'b0;
        chk("R9 nmi low next clock", 64'(nmi_o), 64'd0);
        do_read(upset(make_word(64'h6), 8'd30, NONE), 21'h000040, 1'b0);
        @(negedge clk);
        clr_corr_i = 1'b1; rd_valid_i = 1'b1;
        rd_word_i = upset(make_word(64'h6), 8'd31, NONE);
        rd_addr_i = 21'h000888; rd_bank_i = 1'b1;
        @(negedge clk);
        clr_corr_i = 1'b0; rd_valid_i = 1'b0;
        chk("R9 set wins over clear", 64'(ecc_corr_o), 64'd1);
        chk("R9 new error recorded", 64'(ecc_addr_o), 64'h000888);

        // R11: ignored word while not valid
        clear_both();
        @(negedge clk);
        rd_valid_i = 1'b0;
        rd_word_i = upset(make_word(64'h3), 8'd4, 8'd5);
        rd_addr_i = 21'h1FFFFF; rd_bank_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R11 no flags", {62'd0, ecc_corr_o, ecc_det_o}, 64'd0);
        chk("R11 record unchanged", {42'd0, ecc_addr_o, ecc_bank_o}, {42'd0, 21'h000888, 1'b1});
        chk("R11 no valid", 64'(rd_valid_o), 64'd0);

        summary();
        $finish;
    end

endmodule